// File: doc/BRIEF.md
# Memory Controller Local-Interface Sequencer

This block sits on the user side of a DDR/SDRAM controller and turns two level-type user requests, read and write, into single handshaked transactions on the controller's local request interface. The requests usually come from debounced switches. Only one transaction is outstanding at a time. Every access uses the same fixed address, burst size and write data, so a write followed by a read of the same location shows whether the memory round trip works.

A transaction has three phases. The request stays raised until the controller shows it is ready. The sequencer then waits for the controller's data strobe. The data phase lasts as long as that strobe stays high: write data is supplied while the controller asks for it, and read data is captured while the controller marks it valid. The sequencer then rests until both user requests are released, so one press gives exactly one transaction. It reports completion with a one-cycle pulse and raises a flag while the captured read data equals the fixed write pattern.

Top module: `ctrlSequencer`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle. In the cycle after any clock edge at which reset was high, both request outputs, `done`, `match`, `ctlAddr`, `ctlSize` and `userRdData` are zero.
- R2: In idle, a high `userRd` has priority over `userWr`. In the cycle after the edge that sees both high, `ctlRdReq` is 1 and `ctlWrReq` is 0.
- R3: `ctlRdReq` stays high on every cycle until an edge at which `ctlReady` is sampled high, and is low in the cycle after that edge.
- R4: `ctlWrReq` follows the same rule against `ctlReady`. The two requests are never high together.
- R5: After a read has been accepted, `userRdData` loads `ctlRdData` at every edge where `ctlRdValid` is high, including the first beat, and afterwards holds the last beat.
- R6: While a write is in progress, from its request until the edge at which `ctlWdataReq` is seen low, `ctlWdata` carries the parameter `WR_DATA`. Otherwise it is zero.
- R7: `ctlAddr` equals `FIX_ADDR` and `ctlSize` equals `BURST_LEN` from the first cycle of a request. Both stay stable while the request is held.
- R8: After a transfer ends, no new request is raised until both `userRd` and `userWr` have been low at an edge. Holding a request high gives exactly one transaction.
- R9: `done` is high for exactly one cycle. It is the cycle after the edge that sees the data strobe (`ctlRdValid` or `ctlWdataReq`) low again after the data phase.
- R10: `match` is high exactly when `userRdData` equals `WR_DATA`.
- R11: A write followed by a read of the same location returns `WR_DATA` in every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| userRd | input | 1 | User read request (level) |
| userWr | input | 1 | User write request (level) |
| ctlReady | input | 1 | Controller can accept the current request |
| ctlWdataReq | input | 1 | Controller takes a write beat this cycle |
| ctlRdValid | input | 1 | Controller read data valid this cycle |
| ctlRdData | input | DATA_W | Controller read data |
| ctlRdReq | output | 1 | Read request to the controller |
| ctlWrReq | output | 1 | Write request to the controller |
| ctlAddr | output | ADDR_W | Transaction address |
| ctlSize | output | SIZE_W | Burst length in beats |
| ctlWdata | output | DATA_W | Write data |
| userRdData | output | DATA_W | Last captured read beat |
| done | output | 1 | One-cycle completion pulse |
| match | output | 1 | Captured data equals the write pattern |

## Verification
A user request seen at an edge shows on `ctlRdReq` or `ctlWrReq` in the next cycle. The request falls in the cycle after the edge that samples `ctlReady` high. A read beat shows on `userRdData` and `match` in the cycle after its `ctlRdValid` edge. `done` comes one cycle after the edge that sees the strobe low. The bench runs a behavioural reference that advances on the same edges from the same sampled inputs. It compares every output at the falling edge, half a period after the registers settle, so no check lands on the edge where a value changes. A behavioural controller model with adjustable ready delay, a two-beat burst and a small storage array drives the handshakes. The bench then checks memory content, captured data and request lengths after each scenario.

// File: rtl/ctrlSeqPkg.sv
package ctrlSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_RD_CAP  = 3'd3,
    ST_WR_REQ  = 3'd4,
    ST_WR_WAIT = 3'd5,
    ST_WR_SUP  = 3'd6,
    ST_REST    = 3'd7
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // a transaction leaves idle this edge
    logic latchRd;   // capture a read beat this edge
    logic finish;    // the data phase ends this edge
    logic driveWr;   // write pattern on the bus
  } seqStrobe_t;

endpackage

// File: rtl/seqControl.sv
module seqControl
  import ctrlSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       userRd,
  input  logic       userWr,
  input  logic       ctlReady,
  input  logic       ctlWdataReq,
  input  logic       ctlRdValid,
  output logic       ctlRdReq,
  output logic       ctlWrReq,
  output seqStrobe_t strobe
);

  seqState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (userRd)      stateD = ST_RD_REQ;
        else if (userWr) stateD = ST_WR_REQ;
      end
      ST_RD_REQ:  if (ctlReady)     stateD = ST_RD_WAIT;
      ST_RD_WAIT: if (ctlRdValid)   stateD = ST_RD_CAP;
      ST_RD_CAP:  if (!ctlRdValid)  stateD = ST_REST;
      ST_WR_REQ:  if (ctlReady)     stateD = ST_WR_WAIT;
      ST_WR_WAIT: if (ctlWdataReq)  stateD = ST_WR_SUP;
      ST_WR_SUP:  if (!ctlWdataReq) stateD = ST_REST;
      ST_REST:    if (!userRd && !userWr) stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  assign ctlRdReq = (stateQ == ST_RD_REQ);
  assign ctlWrReq = (stateQ == ST_WR_REQ);

  always_comb begin
    strobe.loadReq = (stateQ == ST_IDLE) && (userRd || userWr);
    strobe.latchRd = ((stateQ == ST_RD_WAIT) || (stateQ == ST_RD_CAP)) && ctlRdValid;
    strobe.finish  = ((stateQ == ST_RD_CAP) && !ctlRdValid) ||
                     ((stateQ == ST_WR_SUP) && !ctlWdataReq);
    strobe.driveWr = (stateQ == ST_WR_REQ) || (stateQ == ST_WR_WAIT) ||
                     (stateQ == ST_WR_SUP);
  end

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import ctrlSeqPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  parameter int BURST_LEN = 2,
  parameter logic [ADDR_W-1:0] FIX_ADDR = '0,
  parameter logic [DATA_W-1:0] WR_DATA = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] ctlRdData,
  output logic [ADDR_W-1:0] ctlAddr,
  output logic [SIZE_W-1:0] ctlSize,
  output logic [DATA_W-1:0] ctlWdata,
  output logic [DATA_W-1:0] userRdData,
  output logic              done,
  output logic              match
);

  localparam logic [SIZE_W-1:0] SIZE_VAL = SIZE_W'(BURST_LEN);

  logic [ADDR_W-1:0] addrQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      sizeQ <= '0;
    end else if (strobe.loadReq) begin
      addrQ <= FIX_ADDR;
      sizeQ <= SIZE_VAL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 rdDataQ <= '0;
    else if (strobe.latchRd) rdDataQ <= ctlRdData;
  end

  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= strobe.finish;
  end

  assign ctlAddr    = addrQ;
  assign ctlSize    = sizeQ;
  assign ctlWdata   = strobe.driveWr ? WR_DATA : '0;
  assign userRdData = rdDataQ;
  assign done       = doneQ;
  assign match      = (rdDataQ == WR_DATA);

endmodule

// File: rtl/ctrlSequencer.sv
module ctrlSequencer
  import ctrlSeqPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  parameter int BURST_LEN = 2,
  parameter logic [ADDR_W-1:0] FIX_ADDR = 24'h000040,
  parameter logic [DATA_W-1:0] WR_DATA = 32'hA5C3_1E7B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              userRd,
  input  logic              userWr,
  input  logic              ctlReady,
  input  logic              ctlWdataReq,
  input  logic              ctlRdValid,
  input  logic [DATA_W-1:0] ctlRdData,
  output logic              ctlRdReq,
  output logic              ctlWrReq,
  output logic [ADDR_W-1:0] ctlAddr,
  output logic [SIZE_W-1:0] ctlSize,
  output logic [DATA_W-1:0] ctlWdata,
  output logic [DATA_W-1:0] userRdData,
  output logic              done,
  output logic              match
);

  seqStrobe_t strobe;

  seqControl u_ctrl (
    .clk(clk), .rst(rst), .userRd(userRd), .userWr(userWr),
    .ctlReady(ctlReady), .ctlWdataReq(ctlWdataReq), .ctlRdValid(ctlRdValid),
    .ctlRdReq(ctlRdReq), .ctlWrReq(ctlWrReq), .strobe(strobe)
  );

  seqDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .BURST_LEN(BURST_LEN), .FIX_ADDR(FIX_ADDR), .WR_DATA(WR_DATA)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .ctlRdData(ctlRdData),
    .ctlAddr(ctlAddr), .ctlSize(ctlSize), .ctlWdata(ctlWdata),
    .userRdData(userRdData), .done(done), .match(match)
  );

endmodule

// File: rtl/ctrlSequencerChk.sv
module ctrlSequencerChk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ctlReady,
  input logic              ctlRdReq,
  input logic              ctlWrReq,
  input logic [ADDR_W-1:0] ctlAddr,
  input logic [SIZE_W-1:0] ctlSize,
  input logic [DATA_W-1:0] userRdData,
  input logic              done
);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!ctlRdReq && !ctlWrReq && !done && userRdData == '0));

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ctlRdReq && !ctlReady) |=> ctlRdReq);

  p_rd_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (ctlRdReq && ctlReady) |=> !ctlRdReq);

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ctlWrReq && !ctlReady) |=> ctlWrReq);

  p_wr_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (ctlWrReq && ctlReady) |=> !ctlWrReq);

  p_one_req_r4: assert property (@(posedge clk) disable iff (rst)
    !(ctlRdReq && ctlWrReq));

  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    ((ctlRdReq || ctlWrReq) && $past(ctlRdReq || ctlWrReq)) |->
      ($stable(ctlAddr) && $stable(ctlSize)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind ctrlSequencer ctrlSequencerChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk(clk), .rst(rst), .ctlReady(ctlReady), .ctlRdReq(ctlRdReq),
  .ctlWrReq(ctlWrReq), .ctlAddr(ctlAddr), .ctlSize(ctlSize),
  .userRdData(userRdData), .done(done)
);

// File: tb/ctrlSequencer_tb.sv
`timescale 1ns/1ps
module ctrlSequencer_tb;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 3;
  localparam int BURST = 2;
  localparam logic [ADDR_W-1:0] FADDR = 24'h000040;
  localparam logic [DATA_W-1:0] WDATA = 32'hA5C3_1E7B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic userRd = 1'b0, userWr = 1'b0;
  logic mReady, mWdReq, mRdValid;
  logic [DATA_W-1:0] mRdData;
  logic ctlRdReq, ctlWrReq, done, match;
  logic [ADDR_W-1:0] ctlAddr;
  logic [SIZE_W-1:0] ctlSize;
  logic [DATA_W-1:0] ctlWdata, userRdData;

  always #10 clk = ~clk;

  ctrlSequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .BURST_LEN(BURST), .FIX_ADDR(FADDR), .WR_DATA(WDATA)
  ) u_dut (
    .clk(clk), .rst(rst), .userRd(userRd), .userWr(userWr),
    .ctlReady(mReady), .ctlWdataReq(mWdReq), .ctlRdValid(mRdValid),
    .ctlRdData(mRdData), .ctlRdReq(ctlRdReq), .ctlWrReq(ctlWrReq),
    .ctlAddr(ctlAddr), .ctlSize(ctlSize), .ctlWdata(ctlWdata),
    .userRdData(userRdData), .done(done), .match(match)
  );

  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural controller model ----------------
  logic [DATA_W-1:0] mem [8];
  int readyDelay = 0;
  int waitCnt, gap, beat, wBeat, accepts;
  int op;  // 0 none, 1 read, 2 write
  logic [ADDR_W-1:0] opAddr, lastAddr;
  logic [SIZE_W-1:0] lastSize;
  logic pokeEn = 1'b0;
  int pokeIdx = 0;
  logic [DATA_W-1:0] pokeVal = '0;

  always @(posedge clk) begin
    if (rst) begin
      mReady <= 1'b0; mWdReq <= 1'b0; mRdValid <= 1'b0; mRdData <= '0;
      waitCnt <= 0; gap <= 0; beat <= 0; wBeat <= 0; op <= 0;
      opAddr <= '0;
      for (int i = 0; i < 8; i++) mem[i] <= 32'h1111_0000 + i;
    end else begin
      if (op == 0) begin
        if ((ctlRdReq || ctlWrReq) && mReady) begin
          op <= ctlRdReq ? 1 : 2;
          gap <= ctlRdReq ? 3 : 1;
          opAddr <= ctlAddr;
          lastAddr <= ctlAddr;
          lastSize <= ctlSize;
          beat <= 0; wBeat <= 0; mReady <= 1'b0; waitCnt <= 0;
          accepts <= accepts + 1;
        end else if (ctlRdReq || ctlWrReq) begin
          if (waitCnt >= readyDelay) mReady <= 1'b1;
          else waitCnt <= waitCnt + 1;
        end
      end else begin
        if (gap > 0) gap <= gap - 1;
        else if (beat < BURST) begin
          if (op == 1) begin
            mRdValid <= 1'b1;
            mRdData <= mem[(int'(opAddr[2:0]) + beat) % 8];
          end else mWdReq <= 1'b1;
          beat <= beat + 1;
        end else begin
          mRdValid <= 1'b0; mWdReq <= 1'b0; mRdData <= '0; op <= 0;
        end
      end
      if (mWdReq) begin
        mem[(int'(opAddr[2:0]) + wBeat) % 8] <= ctlWdata;
        wBeat <= wBeat + 1;
      end
      if (pokeEn) mem[pokeIdx] <= pokeVal;
    end
  end

  initial accepts = 0;

  // ---------------- reference model of the sequencer ----------------
  int refPh;
  logic [DATA_W-1:0] refData;
  logic refDone;

  always @(posedge clk) begin
    if (rst) begin
      refPh <= 0; refData <= '0; refDone <= 1'b0;
    end else begin
      refDone <= (refPh == 3 && !mRdValid) || (refPh == 6 && !mWdReq);
      if ((refPh == 2 || refPh == 3) && mRdValid) refData <= mRdData;
      case (refPh)
        0: if (userRd) refPh <= 1; else if (userWr) refPh <= 4;
        1: if (mReady) refPh <= 2;
        2: if (mRdValid) refPh <= 3;
        3: if (!mRdValid) refPh <= 7;
        4: if (mReady) refPh <= 5;
        5: if (mWdReq) refPh <= 6;
        6: if (!mWdReq) refPh <= 7;
        default: if (!userRd && !userWr) refPh <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(ctlRdReq == (refPh == 1), "R3 read request", 64'(ctlRdReq), 64'(refPh == 1));
      check(ctlWrReq == (refPh == 4), "R4 write request", 64'(ctlWrReq), 64'(refPh == 4));
      check(done == refDone, "R9 done pulse", 64'(done), 64'(refDone));
      check(userRdData == refData, "R5 read capture", 64'(userRdData), 64'(refData));
      check(match == (refData == WDATA), "R10 match flag", 64'(match), 64'(refData == WDATA));
      if (refPh >= 4 && refPh <= 6 || (refPh == 7 && op == 2))
        check(ctlWdata == WDATA, "R6 write data", 64'(ctlWdata), 64'(WDATA));
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    int n;
    int acc0;
    idle(3);
    // R1 reset values
    check(!ctlRdReq && !ctlWrReq, "R1 requests after reset", {ctlRdReq, ctlWrReq}, 0);
    check(userRdData == '0 && !done && !match, "R1 data/done/match after reset",
          64'(userRdData), 0);
    check(ctlAddr == '0 && ctlSize == '0, "R1 address/size after reset", 64'(ctlAddr), 0);
    rst = 1'b0;
    idle(2);

    // write, immediate ready
    readyDelay = 0;
    userWr = 1'b1;
    @(negedge clk);
    check(ctlWrReq == 1'b1, "R4 write request raised", 64'(ctlWrReq), 1);
    check(ctlAddr == FADDR, "R7 address at request", 64'(ctlAddr), 64'(FADDR));
    check(ctlSize == SIZE_W'(BURST), "R7 size at request", 64'(ctlSize), BURST);
    idle(20);
    check(accepts == 1, "R8 one write while held", accepts, 1);
    check(mem[0] == WDATA && mem[1] == WDATA, "R11 both beats written",
          {mem[0], mem[1]}, {WDATA, WDATA});
    check(mem[2] == 32'h1111_0002, "R6 no extra beat written", 64'(mem[2]), 64'h1111_0002);
    check(lastAddr == FADDR && lastSize == SIZE_W'(BURST), "R7 accepted address/size",
          64'(lastAddr), 64'(FADDR));
    idle(20);
    check(accepts == 1 && !ctlRdReq && !ctlWrReq, "R8 no repeat while held", accepts, 1);
    userWr = 1'b0;
    idle(4);

    // read with delayed ready
    readyDelay = 5;
    userRd = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ctlRdReq) n++;
    end
    check(n == 7, "R3 request held until ready", n, 7);
    check(userRdData == WDATA && match, "R11 read back write data", 64'(userRdData), 64'(WDATA));
    userRd = 1'b0;
    idle(4);

    // read with distinct beats: last beat kept
    pokeIdx = 1; pokeVal = 32'h0BAD_F00D; pokeEn = 1'b1;
    @(negedge clk);
    pokeEn = 1'b0;
    readyDelay = 2;
    userRd = 1'b1;
    idle(25);
    check(userRdData == 32'h0BAD_F00D, "R5 last beat held", 64'(userRdData), 64'h0BADF00D);
    check(!match, "R10 match low on mismatch", 64'(match), 0);
    userRd = 1'b0;
    idle(4);

    // both requests high: read wins
    readyDelay = 1;
    acc0 = accepts;
    userRd = 1'b1; userWr = 1'b1;
    @(negedge clk);
    check(ctlRdReq && !ctlWrReq, "R2 read priority", {ctlRdReq, ctlWrReq}, 2'b10);
    idle(30);
    check(accepts == acc0 + 1, "R8 one transaction for both held", accepts - acc0, 1);
    userRd = 1'b0;
    idle(5);
    check(accepts == acc0 + 1 && !ctlWrReq, "R8 rest holds until both low",
          accepts - acc0, 1);
    userWr = 1'b0;
    idle(4);

    // reset during a request
    readyDelay = 8;
    userWr = 1'b1;
    idle(3);
    rst = 1'b1;
    @(negedge clk);
    check(!ctlWrReq && !ctlRdReq && userRdData == '0, "R1 reset mid-request",
          64'(userRdData), 0);
    userWr = 1'b0;
    rst = 1'b0;
    idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule